// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character into an asynchronous serial frame on a single line that rests high. A character enters through a valid/ready handshake together with a frame-format byte. The block then drives a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Bit timing comes from an enable pulse that arrives sixteen times per bit; the block counts those pulses itself, so one clock domain serves any baud rate the surrounding logic chooses.

The format byte selects the character width (5 to 8 bits), whether a parity bit is sent, odd or even parity, and a long or short stop period. The long stop period depends on the width: one and a half bit times for 5-bit characters and two bit times otherwise. Format and data are captured when the character is accepted, so the sender may change them freely while a frame is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the edge that ends the stop period, `busy` is 1 and `in_ready` is 0. A `tick16` pulse on the acceptance edge is not counted.
- R3: The start bit drives `txd` to 0 from the acceptance edge for 16 counted ticks. The data bits follow, least significant first, each for 16 ticks.
- R4: `line_ctrl[1:0]` sets the character width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the width are not sent.
- R5: With `line_ctrl[3]` = 1, one parity bit of 16 ticks follows the data bits. With `line_ctrl[3]` = 0, no parity bit is sent.
- R6: `line_ctrl[4]` = 0 selects odd parity and 1 selects even parity. Parity covers only the data bits inside the selected width.
- R7: The stop period holds `txd` at 1. It lasts 16 ticks when `line_ctrl[2]` = 0. With `line_ctrl[2]` = 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6, 7 or 8 bits.
- R8: The data and format are taken from `in_data` and `line_ctrl` at acceptance. Later changes to those inputs do not affect the frame in progress, and `line_ctrl[7:5]` has no effect.
- R9: `txd` changes only on a clock edge where `tick16` is 1, apart from the acceptance edge. The line stays 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | 8 | Character, bit 0 sent first |
| line_ctrl | input | 8 | Frame format byte |
| tick16 | input | 1 | Enable pulse, 16 per bit time |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that `tick16` is a single-cycle enable sampled on the same clock, and that `in_valid` is not required to wait for `in_ready`. The stimulus drives ticks in an irregular pattern of two pulses in every three cycles, so a missing tick guard in the timer becomes visible. It also raises a tick on the acceptance edge on purpose. The sweep covers every value of the five format bits with several data patterns, so all widths, parity senses and stop lengths are exercised. The data and format inputs are inverted and the unused format bits are varied while each frame is on the line.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

   localparam int unsigned CHAR_MAX_W = 8;
   localparam int unsigned CHAR_MIN_W = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PARITY,
      PH_STOP
   } phase_e;

   typedef enum logic [1:0] {
      STOP_ONE,
      STOP_ONE_HALF,
      STOP_TWO
   } stop_e;

   typedef struct packed {
      logic [3:0] nbits;
      logic       par_en;
      logic       par_even;
      stop_e      stop;
   } frame_fmt_t;

   // Mask keeping only the active character bits.
   function automatic logic [CHAR_MAX_W-1:0] width_mask(input logic [3:0] nbits);
      logic [CHAR_MAX_W-1:0] m;
      for (int i = 0; i < CHAR_MAX_W; i++) begin
         m[i] = (4'(i) < nbits);
      end
      return m;
   endfunction

endpackage

// File: rtl/sftx_fmt_decode.sv
module sftx_fmt_decode
   import sftx_pkg::*;
(
   input  logic [7:0] ctrl_byte,
   output frame_fmt_t fmt
);

   logic unused_hi_bits;
   assign unused_hi_bits = ^ctrl_byte[7:5];

   always_comb begin
      fmt.nbits    = 4'(CHAR_MIN_W) + {2'b00, ctrl_byte[1:0]};
      fmt.par_en   = ctrl_byte[3];
      fmt.par_even = ctrl_byte[4];
      if (!ctrl_byte[2]) begin
         fmt.stop = STOP_ONE;
      end else if (ctrl_byte[1:0] == 2'b00) begin
         fmt.stop = STOP_ONE_HALF;
      end else begin
         fmt.stop = STOP_TWO;
      end
   end

endmodule

// File: rtl/sftx_bit_timer.sv
module sftx_bit_timer #(
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   output logic             done
);

   logic [LEN_W-1:0] cnt;

   assign done = run && tick && (cnt == len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || done) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sftx_serializer.sv
module sftx_serializer
   import sftx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE       = 16,
   parameter bit          PARITY_AT_ACCEPT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic [CHAR_MAX_W-1:0] data_in,
   input  frame_fmt_t            fmt_in,
   input  logic                  tick,
   output logic                  txd,
   output logic                  busy
);

   localparam int unsigned LEN_W = $clog2(2 * OVERSAMPLE) + 1;
   localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(OVERSAMPLE);
   localparam logic [LEN_W-1:0] LEN_1P5  = LEN_W'(OVERSAMPLE + OVERSAMPLE / 2);
   localparam logic [LEN_W-1:0] LEN_TWO  = LEN_W'(2 * OVERSAMPLE);
   localparam int unsigned CNT_BITS_W = $clog2(CHAR_MAX_W);

   phase_e                  phase;
   frame_fmt_t              fmt_q;
   logic [CHAR_MAX_W-1:0]   shreg;
   logic [CNT_BITS_W-1:0]   bits_left;
   logic                    txd_q;
   logic                    par_bit;
   logic                    phase_done;
   logic                    emit_data;
   logic [LEN_W-1:0]        phase_len;
   logic [CHAR_MAX_W-1:0]   data_masked;

   assign data_masked = data_in & width_mask(fmt_in.nbits);

   always_comb begin
      phase_len = LEN_ONE;
      if (phase == PH_STOP) begin
         unique case (fmt_q.stop)
            STOP_ONE_HALF: phase_len = LEN_1P5;
            STOP_TWO:      phase_len = LEN_TWO;
            default:       phase_len = LEN_ONE;
         endcase
      end
   end

   sftx_bit_timer #(.LEN_W(LEN_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (phase != PH_IDLE),
      .tick  (tick),
      .len   (phase_len),
      .done  (phase_done)
   );

   // A data bit leaves the shifter at the end of the start bit and of every data bit but the last.
   assign emit_data = phase_done &&
                      ((phase == PH_START) || ((phase == PH_DATA) && (bits_left != '0)));

   generate
      if (PARITY_AT_ACCEPT) begin : g_par_accept
         logic par_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               par_q <= 1'b0;
            end else if (accept) begin
               par_q <= (^data_masked) ^ ~fmt_in.par_even;
            end
         end
         assign par_bit = par_q;
      end else begin : g_par_running
         logic par_acc;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               par_acc <= 1'b0;
            end else if (accept) begin
               par_acc <= ~fmt_in.par_even;
            end else if (emit_data) begin
               par_acc <= par_acc ^ shreg[0];
            end
         end
         assign par_bit = par_acc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         fmt_q     <= '{nbits: 4'(CHAR_MIN_W), par_en: 1'b0, par_even: 1'b0, stop: STOP_ONE};
         shreg     <= '0;
         bits_left <= '0;
         txd_q     <= 1'b1;
      end else if (accept) begin
         phase     <= PH_START;
         fmt_q     <= fmt_in;
         shreg     <= data_masked;
         bits_left <= CNT_BITS_W'(fmt_in.nbits - 4'd1);
         txd_q     <= 1'b0;
      end else if (phase_done) begin
         unique case (phase)
            PH_START: begin
               phase <= PH_DATA;
               txd_q <= shreg[0];
               shreg <= shreg >> 1;
            end
            PH_DATA: begin
               if (bits_left != '0) begin
                  txd_q     <= shreg[0];
                  shreg     <= shreg >> 1;
                  bits_left <= bits_left - 1'b1;
               end else if (fmt_q.par_en) begin
                  phase <= PH_PARITY;
                  txd_q <= par_bit;
               end else begin
                  phase <= PH_STOP;
                  txd_q <= 1'b1;
               end
            end
            PH_PARITY: begin
               phase <= PH_STOP;
               txd_q <= 1'b1;
            end
            default: begin
               phase <= PH_IDLE;
               txd_q <= 1'b1;
            end
         endcase
      end
   end

   assign txd  = txd_q;
   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import sftx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE       = 16,
   parameter bit          PARITY_AT_ACCEPT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic [7:0] line_ctrl,
   input  logic       tick16,
   output logic       txd,
   output logic       busy
);

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os_small
         $error("serial_frame_tx: OVERSAMPLE must be at least 2");
      end
      if ((OVERSAMPLE % 2) != 0) begin : g_bad_os_odd
         $error("serial_frame_tx: OVERSAMPLE must be even for the 1.5-bit stop");
      end
   endgenerate

   frame_fmt_t fmt_live;
   logic       accept;

   sftx_fmt_decode u_decode (
      .ctrl_byte (line_ctrl),
      .fmt       (fmt_live)
   );

   assign in_ready = !busy;
   assign accept   = in_valid && !busy;

   sftx_serializer #(
      .OVERSAMPLE       (OVERSAMPLE),
      .PARITY_AT_ACCEPT (PARITY_AT_ACCEPT)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .data_in (in_data),
      .fmt_in  (fmt_live),
      .tick    (tick16),
      .txd     (txd),
      .busy    (busy)
   );

endmodule

// File: rtl/sftx_checker.sv
module sftx_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic tick16,
   input logic txd,
   input logic busy
);

   // R2
   accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && !in_ready && !txd));

   // R2
   no_end_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> busy);

   // R9
   line_steady_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> $stable(txd));

   // R9
   idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   // R7
   frame_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (txd && in_ready));

endmodule

bind serial_frame_tx sftx_checker u_sftx_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tick16   (tick16),
   .txd      (txd),
   .busy     (busy)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

   localparam int OS = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic [7:0] line_ctrl = 8'h00;
   logic       tick16 = 1'b0;
   logic       txd;
   logic       busy;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   serial_frame_tx dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .line_ctrl (line_ctrl),
      .tick16    (tick16),
      .txd       (txd),
      .busy      (busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic [7:0] c);
      int n, stop_t, total, seen, ones, pe;
      int bad_at, bad_act, bad_exp, busy_bad;
      string bad_req;
      logic par, expv;
      n      = 5 + int'(c[1:0]);                          // R4
      pe     = int'(c[3]);                                // R5
      stop_t = !c[2] ? OS : ((c[1:0] == 2'b00) ? OS + OS / 2 : 2 * OS); // R7
      total  = OS * (1 + n + pe) + stop_t;
      ones   = 0;
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      par    = c[4] ? logic'(ones % 2) : ~logic'(ones % 2); // R6
      @(negedge clk);
      check(in_ready === 1'b1, "R2", "ready before offer", int'(in_ready), 1);
      in_valid = 1'b1; in_data = d; line_ctrl = c;
      tick16 = 1'b1;                                      // R2: not counted
      @(negedge clk);
      in_valid = 1'b0; in_data = ~d; line_ctrl = ~c;      // R8
      tick16 = 1'b0;
      seen = 0; bad_at = -1; busy_bad = 0;
      bad_req = ""; bad_act = 0; bad_exp = 0;
      while (seen < total) begin
         int j;
         j = seen / OS;
         if (j == 0) begin
            expv = 1'b0; bad_req = (bad_at < 0) ? "R3" : bad_req;
         end else if (j <= n) begin
            expv = d[j-1];
            if (bad_at < 0) bad_req = "R4/R8";
         end else if (j == n + 1 && pe == 1) begin
            expv = par;
            if (bad_at < 0) bad_req = "R5/R6";
         end else begin
            expv = 1'b1;
            if (bad_at < 0) bad_req = "R7";
         end
         if (txd !== expv && bad_at < 0) begin
            bad_at = seen; bad_act = int'(txd); bad_exp = int'(expv);
         end
         if (busy !== 1'b1 || in_ready !== 1'b0) busy_bad++;
         cyc++;
         tick16 = (cyc % 3 != 0);
         if (tick16) seen++;
         @(negedge clk);
      end
      tick16 = 1'b0;
      check(bad_at < 0, bad_req, $sformatf("line d=%02h c=%02h tick %0d", d, c, bad_at),
            bad_act, bad_exp);
      check(busy_bad == 0, "R2", $sformatf("busy/ready low during frame c=%02h", c),
            busy_bad, 0);
      check(busy === 1'b0 && in_ready === 1'b1 && txd === 1'b1, "R7",
            $sformatf("idle after stop c=%02h (busy,ready,txd)", c),
            int'({busy, in_ready, txd}), 3'b011);
   endtask

   initial begin
      logic [7:0] pats [5];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h37;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
      check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
      check(in_ready === 1'b1, "R1", "ready after reset", int'(in_ready), 1);
      for (int p = 0; p < 5; p++) begin
         for (int cv = 0; cv < 32; cv++) begin
            send_frame(pats[p], {3'(p + cv), 5'(cv)});
         end
      end
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule